// File: doc/BRIEF.md
# Two-Wire Debug Escape Detector

The block watches a two-wire debug port that has a test clock line and a shared data/mode line. On that port an escape is a burst of transitions on the data/mode line made while the test clock stays high. Both lines are brought into a faster system clock domain through multi-stage synchronizers. The block counts the data-line transitions seen during each high phase of the test clock. It classifies that count at the next rising edge of the test clock.

Exactly six transitions produce a one-cycle request to start the activation phase. Eight or more produce a one-cycle request to fall back to four-wire operation. Every other count produces no request. The counter clears at every rising test-clock edge, and it saturates so that very long bursts still count as eight or more. A surrounding port controller uses the two pulses to change its operating mode.

Top module: `esc_detector`

## Requirements
- R1: While `rst` (active-high, synchronous) is asserted, and afterwards until an escape is classified, `activate_req` and `return_req` are 0, and the transition count is zero.
- R2: A high phase of `tck_in` with exactly 6 `tms_in` transitions causes exactly one `activate_req` pulse after the next rising edge of `tck_in`, and no `return_req`.
- R3: A high phase with 8 or more `tms_in` transitions causes exactly one `return_req` pulse after the next rising edge of `tck_in`, and no `activate_req`.
- R4: A high phase with exactly 7 transitions produces no pulse on either output.
- R5: A high phase with 0 to 5 transitions produces no pulse on either output.
- R6: Rising and falling transitions of `tms_in` count the same, whatever level the line has when the burst starts.
- R7: The count clears at every rising edge of `tck_in`, so transitions from separate high phases never add up.
- R8: Transitions of `tms_in` while `tck_in` is low are not counted.
- R9: The count saturates at its maximum (15 for a 4-bit counter), so a burst of any length above 8 still gives `return_req`.
- R10: Each pulse lasts one system clock cycle. It rises no more than 8 system cycles after the rising edge of `tck_in`, and never without a preceding rising test-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the test clock |
| rst | input | 1 | Synchronous active-high reset |
| tck_in | input | 1 | Asynchronous test clock line |
| tms_in | input | 1 | Asynchronous data/mode line |
| activate_req | output | 1 | One-cycle request to enter the activation phase |
| return_req | output | 1 | One-cycle request to return to four-wire mode |

## Verification
The hardest case to reach is a count that has reached saturation and then sits beside a rising test-clock edge. If the clear fails there, a later short burst is classified wrongly. The bench makes bursts of up to 40 toggles, then follows them at once with short and seven-toggle bursts, and checks that no request leaks into the next phase. Randomly mixed low-phase toggles also test that only transitions during the high phase count.

// File: rtl/esc_pkg.sv
package esc_pkg;

    typedef enum logic [1:0] {
        BURST_NONE     = 2'd0,
        BURST_ACTIVATE = 2'd1,
        BURST_RETURN   = 2'd2
    } burst_e;

    typedef struct packed {
        logic tck_high;
        logic tck_rise;
        logic tms_toggle;
    } line_ev_t;

    function automatic burst_e classify_count(input int unsigned cnt,
                                              input int unsigned act_cnt,
                                              input int unsigned ret_min);
        burst_e res;
        if (cnt >= ret_min)
            res = BURST_RETURN;
        else if (cnt == act_cnt)
            res = BURST_ACTIVATE;
        else
            res = BURST_NONE;
        return res;
    endfunction

endpackage

// File: rtl/esc_sync.sv
module esc_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] async_in,
    output logic [LINES-1:0] sync_out
);
    logic [LINES-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/esc_edge_det.sv
module esc_edge_det
    import esc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tck_s,
    input  logic     tms_s,
    output line_ev_t ev
);
    logic tck_prev_q;
    logic tms_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tck_prev_q <= 1'b0;
            tms_prev_q <= 1'b0;
        end else begin
            tck_prev_q <= tck_s;
            tms_prev_q <= tms_s;
        end
    end

    always_comb begin
        ev.tck_rise   = tck_s & ~tck_prev_q;
        ev.tck_high   = tck_s & tck_prev_q;
        ev.tms_toggle = tms_s ^ tms_prev_q;
    end
endmodule

// File: rtl/esc_toggle_counter.sv
module esc_toggle_counter
    import esc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  line_ev_t         ev,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (ev.tck_rise)
            cnt_q <= '0;
        else if (ev.tck_high && ev.tms_toggle && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    // R7
    clear_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ev.tck_rise |=> cnt_q == '0);

    // R8
    low_phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ev.tck_high && !ev.tck_rise) |=> $stable(cnt_q));

    // R9
    saturate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !ev.tck_rise) |=> cnt_q == CNT_MAX);

    // R6
    step_bound_chk: assert property (@(posedge clk) disable iff (rst)
        !ev.tck_rise |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/esc_classifier.sv
module esc_classifier
    import esc_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int ACT_CNT = 6,
    parameter int RET_MIN = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  line_ev_t         ev,
    input  logic [CNT_W-1:0] count,
    output logic             act_pulse,
    output logic             ret_pulse
);
    burst_e kind;
    logic   act_q;
    logic   ret_q;

    always_comb begin
        kind = classify_count(int'(count), ACT_CNT, RET_MIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            ret_q <= 1'b0;
        end else begin
            act_q <= ev.tck_rise && (kind == BURST_ACTIVATE);
            ret_q <= ev.tck_rise && (kind == BURST_RETURN);
        end
    end

    assign act_pulse = act_q;
    assign ret_pulse = ret_q;

    // R10
    act_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
        act_q |-> $past(ev.tck_rise));

    // R10
    ret_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ret_q |-> $past(ev.tck_rise));

    // R10
    act_single_chk: assert property (@(posedge clk) disable iff (rst)
        act_q |=> !act_q);

    // R10
    ret_single_chk: assert property (@(posedge clk) disable iff (rst)
        ret_q |=> !ret_q);
endmodule

// File: rtl/esc_detector.sv
module esc_detector
    import esc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4,
    parameter int ACT_CNT     = 6,
    parameter int RET_MIN     = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tck_in,
    input  logic tms_in,
    output logic activate_req,
    output logic return_req
);
    localparam int LINES = 2;

    logic [LINES-1:0] sync_v;
    line_ev_t         ev;
    logic [CNT_W-1:0] count;

    esc_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in ({tms_in, tck_in}),
        .sync_out (sync_v)
    );

    esc_edge_det edge_i (
        .clk   (clk),
        .rst   (rst),
        .tck_s (sync_v[0]),
        .tms_s (sync_v[1]),
        .ev    (ev)
    );

    esc_toggle_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .count (count)
    );

    esc_classifier #(.CNT_W(CNT_W), .ACT_CNT(ACT_CNT), .RET_MIN(RET_MIN)) cls_i (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .count     (count),
        .act_pulse (activate_req),
        .ret_pulse (return_req)
    );

    // R2
    req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(activate_req && return_req));
endmodule

// File: tb/esc_detector_tb.sv
module esc_detector_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tck_in = 1'b0;
    logic tms_in = 1'b0;
    logic activate_req, return_req;

    int n_checks = 0;
    int n_fail = 0;
    int act_seen = 0;
    int ret_seen = 0;
    int wide_pulses = 0;
    logic act_d = 1'b0;
    logic ret_d = 1'b0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    esc_detector dut_i (
        .clk          (clk),
        .rst          (rst),
        .tck_in       (tck_in),
        .tms_in       (tms_in),
        .activate_req (activate_req),
        .return_req   (return_req)
    );

    // pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (activate_req) act_seen++;
            if (return_req)   ret_seen++;
            if ((activate_req && act_d) || (return_req && ret_d)) wide_pulses++;
        end
        act_d = activate_req;
        ret_d = return_req;
    end

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_act(input int n);
        return (n == 6) ? 1 : 0;
    endfunction

    function automatic int exp_ret(input int n);
        return (n >= 8) ? 1 : 0;
    endfunction

    // low-phase toggles, then a high phase with n_high toggles, then the
    // classifying rising edge; pulses counted in a window after it
    task automatic burst(input string req, input int n_high, input int n_low);
        int a0, r0;
        for (int i = 0; i < n_low; i++) begin
            tms_in = ~tms_in; cycles(3);
        end
        tck_in = 1'b1; cycles(6);
        for (int i = 0; i < n_high; i++) begin
            tms_in = ~tms_in; cycles(3);
        end
        cycles(2);
        tck_in = 1'b0; cycles(6);
        a0 = act_seen; r0 = ret_seen;
        tck_in = 1'b1;
        cycles(8);
        check({req, " activate"}, act_seen - a0, exp_act(n_high));
        check({req, " return"},   ret_seen - r0, exp_ret(n_high));
        tck_in = 1'b0; cycles(6);
    endtask

    initial begin
        void'($urandom(32'd24681));
        cycles(4);
        // R1: outputs during reset
        check("R1 reset act", int'(activate_req), 0);
        check("R1 reset ret", int'(return_req), 0);
        rst = 1'b0;
        cycles(4);
        burst("R1 empty", 0, 0);
        burst("R2 six", 6, 0);
        tms_in = 1'b1; cycles(4);
        burst("R6 six from high", 6, 0);
        burst("R3 eight", 8, 0);
        burst("R3 nine", 9, 0);
        burst("R4 seven", 7, 0);
        for (int k = 1; k <= 5; k++) burst("R5 short", k, 0);
        burst("R7 split a", 3, 0);
        burst("R7 split b", 3, 0);
        burst("R8 low only", 0, 6);
        burst("R8 low mixed", 6, 3);
        burst("R9 fifteen", 15, 0);
        burst("R9 forty", 40, 0);
        burst("R7 after saturate", 2, 0);
        burst("R9 twenty", 20, 0);
        burst("R7 seven after sat", 7, 0);
        for (int k = 0; k < 30; k++) begin
            int nh, nl;
            nh = int'($urandom % 20);
            nl = int'($urandom % 4);
            burst("R2/R3 random", nh, nl);
        end
        // R10: single-cycle pulses throughout
        check("R10 pulse width", wide_pulses, 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule